// File: doc/BRIEF.md
# Instruction Cache Tag Invalidation Sequencer

This block clears the tag store of a set-associative instruction cache after every hardware reset, with no software involvement. A line-index counter walks from 0 to `LINES-1`, one index per clock. At each index it writes a cleared valid bit into every way at once. It also writes way code 0 into that set's replacement pointer, so the first fill of any set after reset lands in way 0.

While the sweep is still running, any fetch request from the CPU is held off by a stall output. The stall ends in the cycle after the last index has been written. A done flag then rises and stays high until the next reset. A reset that arrives in the middle of a sweep starts the walk again from index 0. Hit/miss logic, data arrays and refill sit outside this block; they only use its tag write port, replacement write port, stall and done outputs.

Top module: `tag_clear_seq`

## Requirements
- R1: While `rst` is high (from the first clock edge with reset), `done` is 0, `tagIdx` is 0 and the sweep is armed: `tagWe` is all ones and `stall` follows `fetchReq`.
- R2: After reset is released, `tagIdx` presents 0, 1, …, `LINES-1` on consecutive cycles. Exactly `LINES` write cycles occur between reset release and the rise of `done`.
- R3: Each sweep cycle writes all `WAYS` ways together (`tagWe` all ones), and the written valid bit `tagValid` is always 0.
- R4: `stall` is 1 exactly when `fetchReq` is 1 and the sweep is still active. It is 0 in the cycle after the last index is written.
- R5: `done` rises in the cycle after index `LINES-1` is written, rises once per reset, and stays 1 until the next reset.
- R6: A reset asserted during a sweep restarts the index at 0, and a full `LINES`-cycle sweep follows its release.
- R7: On every sweep write, `replWe` is 1 and `replWay` is 0 (way code 0 = way 0), so the next fill of each set targets way 0.
- R8: Once `done` is 1, `tagWe` and `replWe` stay 0 and `fetchReq` has no effect on `stall`, which stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchReq | input | 1 | CPU instruction fetch request |
| stall | output | 1 | Holds the fetch off while the sweep runs |
| tagIdx | output | IDX_W | Line index of the tag write |
| tagWe | output | WAYS | Per-way tag write enable |
| tagValid | output | 1 | Valid bit written to the tag (always 0) |
| replWe | output | 1 | Replacement pointer write enable |
| replWay | output | WAY_W | Replacement pointer value written (way 0) |
| done | output | 1 | Sweep complete, high until next reset |

## Verification
The stall decision and the end of the sweep fall in the same cycle when a fetch request is present while the last index, `LINES-1`, is being written. The bench holds `fetchReq` high across that boundary. It expects `stall` high in the last write cycle and low in the very next one, the cycle in which `done` rises. A reset landing mid-sweep, while a fetch is pending, also coincides with a write. There the bench expects the index to go back to 0 and the stall to persist.

// File: rtl/tag_clear_pkg.sv
package tag_clear_pkg;
  // Strobes from the sequencing control to the index datapath
  typedef struct packed {
    logic clrIdx;   // return index counter to 0
    logic stepIdx;  // advance index counter by one
    logic wrAll;    // write every way at the current index
  } sweepCtl_t;

  typedef enum logic {
    ST_SWEEP = 1'b0,
    ST_IDLE  = 1'b1
  } sweepState_t;
endpackage

// File: rtl/tag_clear_ctrl.sv
module tag_clear_ctrl
  import tag_clear_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      fetchReq,
  input  logic      lastIdx,
  output sweepCtl_t ctl,
  output logic      stall,
  output logic      done
);
  sweepState_t state;
  logic        doneQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_SWEEP;
      doneQ <= 1'b0;
    end else if (state == ST_SWEEP && lastIdx) begin
      state <= ST_IDLE;
      doneQ <= 1'b1;
    end
  end

  always_comb begin
    ctl.clrIdx  = rst;
    ctl.stepIdx = (state == ST_SWEEP) && !lastIdx;
    ctl.wrAll   = (state == ST_SWEEP);
  end

  assign stall = fetchReq && (state == ST_SWEEP);
  assign done  = doneQ;

  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> doneQ);

  assert_done_after_last_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(doneQ) |-> $past(lastIdx));

  assert_stall_pending_R4: assert property (@(posedge clk) disable iff (rst)
    (fetchReq && !doneQ) |-> stall);

  assert_no_stall_idle_R8: assert property (@(posedge clk) disable iff (rst)
    doneQ |-> !stall);
endmodule

// File: rtl/tag_clear_dp.sv
module tag_clear_dp
  import tag_clear_pkg::*;
#(
  parameter int LINES = 128,
  parameter int WAYS  = 4,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  sweepCtl_t        ctl,
  output logic             lastIdx,
  output logic [IDX_W-1:0] tagIdx,
  output logic [WAYS-1:0]  tagWe,
  output logic             tagValid,
  output logic             replWe,
  output logic [WAY_W-1:0] replWay
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (ctl.clrIdx)       idx <= '0;
    else if (ctl.stepIdx) idx <= idx + 1'b1;
  end

  assign lastIdx = (idx == LAST);
  assign tagIdx  = idx;

  for (genvar w = 0; w < WAYS; w++) begin : gWayWe
    assign tagWe[w] = ctl.wrAll;
  end

  assign tagValid = 1'b0;
  assign replWe   = ctl.wrAll;
  assign replWay  = '0;

  assert_idx_step_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl.wrAll && $past(ctl.wrAll) && !$past(rst)) |-> (idx == $past(idx) + 1'b1));

  assert_repl_with_tag_R7: assert property (@(posedge clk) disable iff (rst)
    (|tagWe) |-> (replWe && replWay == '0));

  assert_valid_cleared_R3: assert property (@(posedge clk) disable iff (rst)
    (|tagWe) |-> (!tagValid && &tagWe));
endmodule

// File: rtl/tag_clear_seq.sv
module tag_clear_seq
  import tag_clear_pkg::*;
#(
  parameter int LINES = 128,
  parameter int WAYS  = 4,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetchReq,
  output logic             stall,
  output logic [IDX_W-1:0] tagIdx,
  output logic [WAYS-1:0]  tagWe,
  output logic             tagValid,
  output logic             replWe,
  output logic [WAY_W-1:0] replWay,
  output logic             done
);
  sweepCtl_t ctl;
  logic      lastIdx;

  tag_clear_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .fetchReq (fetchReq),
    .lastIdx  (lastIdx),
    .ctl      (ctl),
    .stall    (stall),
    .done     (done)
  );

  tag_clear_dp #(.LINES(LINES), .WAYS(WAYS)) uDp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .lastIdx  (lastIdx),
    .tagIdx   (tagIdx),
    .tagWe    (tagWe),
    .tagValid (tagValid),
    .replWe   (replWe),
    .replWay  (replWay)
  );
endmodule

// File: tb/tb_tag_clear_seq.sv
module tb_tag_clear_seq;
  localparam int LINES = 128;
  localparam int WAYS  = 4;
  localparam int IDX_W = $clog2(LINES);
  localparam int WAY_W = $clog2(WAYS);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             fetchReq = 1'b0;
  logic             stall, tagValid, replWe, done;
  logic [IDX_W-1:0] tagIdx;
  logic [WAYS-1:0]  tagWe;
  logic [WAY_W-1:0] replWay;

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;

  // behavioural reference state
  int mIdx;
  bit mActive;
  bit mDone;
  bit mValid = 1'b0;
  int writesSinceRelease;
  int doneRises;
  bit prevDone;

  always #5 clk = ~clk;

  tag_clear_seq #(.LINES(LINES), .WAYS(WAYS)) dut (
    .clk(clk), .rst(rst), .fetchReq(fetchReq), .stall(stall),
    .tagIdx(tagIdx), .tagWe(tagWe), .tagValid(tagValid),
    .replWe(replWe), .replWay(replWay), .done(done)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // advance one clock: update model at the edge, compare at the falling edge
  task automatic cycle(input bit nextRst, input bit nextReq);
    rst = nextRst;
    fetchReq = nextReq;
    @(posedge clk);
    if (rst) begin
      mIdx = 0; mActive = 1'b1; mDone = 1'b0; mValid = 1'b1;
      writesSinceRelease = 0;
    end else if (mActive) begin
      writesSinceRelease++;
      if (mIdx == LINES - 1) begin
        mActive = 1'b0; mDone = 1'b1;
      end else mIdx++;
    end
    @(negedge clk);
    if (mValid) begin
      check(rst ? "R1 stall" : "R4 stall", int'(stall), int'(fetchReq && mActive));
      check(rst ? "R1 done" : "R5 done", int'(done), int'(mDone));
      check(mDone ? "R8 tagWe" : "R3 tagWe", int'(tagWe), mActive ? (1 << WAYS) - 1 : 0);
      check("R3 tagValid", int'(tagValid), 0);
      check(mDone ? "R8 replWe" : "R7 replWe", int'(replWe), int'(mActive));
      if (mActive) begin
        check(rst ? "R1 tagIdx" : "R2 tagIdx", int'(tagIdx), mIdx);
        check("R7 replWay", int'(replWay), 0);
      end
      if (done && !prevDone) doneRises++;
      prevDone = done;
    end
  endtask

  initial begin
    // R1: reset held with a fetch pending
    cycle(1'b1, 1'b1);
    cycle(1'b1, 1'b1);
    cycle(1'b1, 1'b0);
    // R6: partial sweep, fetch toggling, then reset mid-sweep with fetch pending
    for (int i = 0; i < 40; i++) cycle(1'b0, i[0]);
    cycle(1'b1, 1'b1);
    cycle(1'b1, 1'b1);
    doneRises = 0;
    prevDone = 1'b0;
    // R2/R4/R5: full sweep with fetch held high across the final index
    for (int i = 0; i < LINES - 1; i++) cycle(1'b0, 1'b1);
    check("R4 stall on last index", int'(stall), 1);
    cycle(1'b0, 1'b1);
    check("R4 stall drops after last index", int'(stall), 0);
    check("R2 write cycle count", writesSinceRelease, LINES);
    // R8: fetches after completion are ignored
    for (int i = 0; i < 20; i++) cycle(1'b0, (i % 3) == 0);
    check("R5 single done rise", doneRises, 1);
    check("R5 done held", int'(done), 1);
    // second reset, sparse fetches, complete again (R6 restart from 0)
    cycle(1'b1, 1'b0);
    check("R6 index back to 0", int'(tagIdx), 0);
    for (int i = 0; i < LINES + 10; i++) cycle(1'b0, (i % 5) == 1);
    check("R2 write cycle count after second reset", writesSinceRelease, LINES);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule